// File: doc/BRIEF.md
# Banked Register Window Bridge

This block lets a host whose address window is only 8 bits wide reach a much larger register space. Each target is named by a full address: a 5-bit device group number placed above a 16-bit register number. The host cannot address that space directly. It first writes the upper part of the full address, which is everything above the low 8 bits, into a bank register. That register sits at window offset 0xFF. Every other window offset then selects the register whose address is the stored bank followed by that offset.

The backing store is an internal array of 16-bit registers. Its depth is a parameter, and it covers full addresses from zero upward. Host words are 32 bits wide. Only the low 16 bits carry register data, and the upper half of every read word is zero.

Two full addresses give fixed answers instead of array contents. These are registers 2 and 3 of vendor device group 31, which return the upper and lower halves of a 32-bit identifier parameter. A full address beyond the array reads as all ones and does not accept writes.

Top module: `bank_window_bridge`

## Requirements
- R1: After reset the bank register is 0. A read at window offset 0xFF returns the bank value in bits 15:0 of the read word.
- R2: A write at offset 0xFF loads the bank from wdata[15:0]. It changes no data register.
- R3: An access at any offset other than 0xFF reaches full address (bank << 8) | offset, using the bank value written most recently. Two banks hold independent values at the same offset.
- R4: A data write stores wdata[15:0] and ignores wdata[31:16]. Bits 31:16 of every read word are zero.
- R5: rdata and rvalid update one clock after a cycle with rd_en high, and rvalid is high only in that cycle. Both are 0 after reset.
- R6: Full address 0x1F0002 reads as ID_VALUE[31:16] and full address 0x1F0003 reads as ID_VALUE[15:0]. Writes to these two addresses have no effect.
- R7: A full address at or above MEM_DEPTH (other than the two identifier addresses) reads as 0x0000FFFF. A write to such an address is ignored, and it does not wrap into the array.
- R8: Reset clears every array register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_addr | input | 8 | Window offset; 0xFF selects the bank register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High for one cycle when rdata holds a read result |

## Verification
The hardest case to reach from the ports is aliasing. An out-of-range full address must not wrap onto an in-range register. To reach it, the bench first stores a known value at full address 0, then selects bank 2. With the default depth of 512, bank 2 offset 0 is address 0x200, whose low index bits match address 0. The bench writes there and returns to bank 0 to confirm that address 0 is unchanged. The identifier addresses need bank 0x1F00, which the bench sets, and it attempts a write before reading them back.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
    localparam int WIN_W  = 8;
    localparam int DATA_W = 16;
    localparam int BUS_W  = 32;

    localparam logic [WIN_W-1:0] BANK_SLOT = 8'hFF;

    localparam logic [4:0]  VEND_GROUP = 5'd31;
    localparam logic [15:0] ID_HI_REG  = 16'd2;
    localparam logic [15:0] ID_LO_REG  = 16'd3;

    typedef enum logic [2:0] {
        ACC_BANK,
        ACC_ID_HI,
        ACC_ID_LO,
        ACC_ARRAY,
        ACC_VOID
    } acc_kind_e;

    function automatic logic [23:0] full_addr(input logic [4:0] grp,
                                              input logic [15:0] regnum);
        return {3'b000, grp, regnum};
    endfunction

    function automatic logic [BUS_W-1:0] widen(input logic [DATA_W-1:0] v);
        return {{(BUS_W-DATA_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/bwb_bank_reg.sv
module bwb_bank_reg #(
    parameter int BANK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)       bank <= '0;
        else if (load) bank <= din;
    end
endmodule

// File: rtl/bwb_decode.sv
module bwb_decode
    import bwb_pkg::*;
#(
    parameter int BANK_W    = 16,
    parameter int MEM_DEPTH = 512,
    localparam int FULL_W   = BANK_W + WIN_W,
    localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [WIN_W-1:0]  offset,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [FULL_W-1:0] DEPTH_LIM = FULL_W'(MEM_DEPTH);
    localparam logic [FULL_W-1:0] ID_HI_A   = FULL_W'(full_addr(VEND_GROUP, ID_HI_REG));
    localparam logic [FULL_W-1:0] ID_LO_A   = FULL_W'(full_addr(VEND_GROUP, ID_LO_REG));

    logic [FULL_W-1:0] composed;

    assign composed = {bank, offset};
    assign idx      = composed[IDX_W-1:0];

    always_comb begin
        if (offset == BANK_SLOT)        kind = ACC_BANK;
        else if (composed == ID_HI_A)   kind = ACC_ID_HI;
        else if (composed == ID_LO_A)   kind = ACC_ID_LO;
        else if (composed < DEPTH_LIM)  kind = ACC_ARRAY;
        else                            kind = ACC_VOID;
    end
endmodule

// File: rtl/bwb_reg_array.sv
module bwb_reg_array
    import bwb_pkg::*;
#(
    parameter int MEM_DEPTH = 512,
    localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= din;
        end
    end

    assign dout = mem[idx];
endmodule

// File: rtl/bank_window_bridge.sv
module bank_window_bridge
    import bwb_pkg::*;
#(
    parameter int          BANK_W    = 16,
    parameter int          MEM_DEPTH = 512,
    parameter logic [31:0] ID_VALUE  = 32'h0B1E_7701
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] win_addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid
);
    localparam int IDX_W = $clog2(MEM_DEPTH);

    logic [BANK_W-1:0] bank_q;
    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] arr_dout;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[BUS_W-1:DATA_W];

    bwb_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (wr_en && (kind == ACC_BANK)),
        .din  (BANK_W'(wdata[DATA_W-1:0])),
        .bank (bank_q)
    );

    bwb_decode #(.BANK_W(BANK_W), .MEM_DEPTH(MEM_DEPTH)) u_dec (
        .bank   (bank_q),
        .offset (win_addr),
        .kind   (kind),
        .idx    (idx)
    );

    bwb_reg_array #(.MEM_DEPTH(MEM_DEPTH)) u_arr (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en && (kind == ACC_ARRAY)),
        .idx  (idx),
        .din  (wdata[DATA_W-1:0]),
        .dout (arr_dout)
    );

    logic [DATA_W-1:0] rd_sel;

    always_comb begin
        unique case (kind)
            ACC_BANK:  rd_sel = DATA_W'(bank_q);
            ACC_ID_HI: rd_sel = ID_VALUE[31:16];
            ACC_ID_LO: rd_sel = ID_VALUE[15:0];
            ACC_ARRAY: rd_sel = arr_dout;
            default:   rd_sel = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= widen(rd_sel);
        end
    end
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker
    import bwb_pkg::*;
#(
    parameter int          BANK_W    = 16,
    parameter int          MEM_DEPTH = 512,
    parameter logic [31:0] ID_VALUE  = 32'h0B1E_7701
) (
    input logic              clk,
    input logic              rst,
    input logic [WIN_W-1:0]  win_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  rdata,
    input logic              rvalid,
    input logic [BANK_W-1:0] bank
);
    localparam int FULL_W = BANK_W + WIN_W;
    logic [FULL_W-1:0] comp;
    logic              is_id;
    assign comp  = {bank, win_addr};
    assign is_id = (comp == FULL_W'(24'h1F0002)) || (comp == FULL_W'(24'h1F0003));

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);                                                  // R5
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);                                                // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rdata[BUS_W-1:DATA_W] == '0));                          // R4
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && win_addr == 8'hFF) |=> (bank == BANK_W'($past(wdata[DATA_W-1:0])))); // R2
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && win_addr == 8'hFF) |=> $stable(bank));                   // R3
    AST_ID_HI: assert property (@(posedge clk) disable iff (rst)
        (rd_en && comp == FULL_W'(24'h1F0002)) |=> (rdata == {16'h0, ID_VALUE[31:16]})); // R6
    AST_ID_LO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && comp == FULL_W'(24'h1F0003)) |=> (rdata == {16'h0, ID_VALUE[15:0]}));  // R6
    AST_VOID_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win_addr != 8'hFF && !is_id && comp >= FULL_W'(MEM_DEPTH))
        |=> (rdata == 32'h0000_FFFF));                                      // R7
endmodule

bind bank_window_bridge bwb_checker #(
    .BANK_W(BANK_W), .MEM_DEPTH(MEM_DEPTH), .ID_VALUE(ID_VALUE)
) u_bwb_checker (
    .clk(clk), .rst(rst), .win_addr(win_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .bank(bank_q)
);

// File: tb/test_bank_window_bridge.sv
`timescale 1ns/1ps
module test_bank_window_bridge;
    localparam logic [31:0] ID_V = 32'h0B1E_7701;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  win_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bank_window_bridge #(.BANK_W(16), .MEM_DEPTH(512), .ID_VALUE(ID_V)) i_bank_window_bridge (
        .clk(clk), .rst(rst), .win_addr(win_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    // vector: {req[3:0], is_write, offset[7:0], wdata[31:0], expected[15:0]}
    localparam int NV = 27;
    localparam logic [60:0] VEC [NV] = '{
        {4'd1, 1'b0, 8'hFF, 32'h0,          16'h0000}, // R1 bank reads 0
        {4'd4, 1'b1, 8'h10, 32'hDEAD_1234,  16'h0000}, // R4 upper half dropped
        {4'd4, 1'b0, 8'h10, 32'h0,          16'h1234}, // R4
        {4'd4, 1'b1, 8'h00, 32'h0000_00A5,  16'h0000}, // R4 addr 0
        {4'd2, 1'b1, 8'hFF, 32'hFFFF_0001,  16'h0000}, // R2 bank=1
        {4'd1, 1'b0, 8'hFF, 32'h0,          16'h0001}, // R1 readback
        {4'd3, 1'b0, 8'h10, 32'h0,          16'h0000}, // R3 0x110 untouched
        {4'd3, 1'b1, 8'h10, 32'h0000_BEEF,  16'h0000}, // R3
        {4'd3, 1'b0, 8'h10, 32'h0,          16'hBEEF}, // R3
        {4'd2, 1'b1, 8'hFF, 32'h0,          16'h0000}, // R2 bank=0
        {4'd2, 1'b0, 8'h10, 32'h0,          16'h1234}, // R2 data intact
        {4'd3, 1'b0, 8'h00, 32'h0,          16'h00A5}, // R3
        {4'd2, 1'b1, 8'hFF, 32'h0000_1F00,  16'h0000}, // R2 bank=0x1F00
        {4'd6, 1'b0, 8'h02, 32'h0,          16'h0B1E}, // R6 id hi
        {4'd6, 1'b0, 8'h03, 32'h0,          16'h7701}, // R6 id lo
        {4'd6, 1'b1, 8'h02, 32'h0000_5555,  16'h0000}, // R6 write ignored
        {4'd6, 1'b1, 8'h03, 32'h0000_AAAA,  16'h0000}, // R6
        {4'd6, 1'b0, 8'h02, 32'h0,          16'h0B1E}, // R6
        {4'd6, 1'b0, 8'h03, 32'h0,          16'h7701}, // R6
        {4'd7, 1'b0, 8'h04, 32'h0,          16'hFFFF}, // R7 void near id
        {4'd2, 1'b1, 8'hFF, 32'h0000_0002,  16'h0000}, // R2 bank=2
        {4'd7, 1'b0, 8'h00, 32'h0,          16'hFFFF}, // R7 0x200 void
        {4'd7, 1'b1, 8'h00, 32'h0000_7777,  16'h0000}, // R7 write ignored
        {4'd7, 1'b0, 8'h00, 32'h0,          16'hFFFF}, // R7
        {4'd2, 1'b1, 8'hFF, 32'h0,          16'h0000}, // R2 bank=0
        {4'd7, 1'b0, 8'h00, 32'h0,          16'h00A5}, // R7 no wrap to 0
        {4'd3, 1'b0, 8'h10, 32'h0,          16'h1234}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        win_addr = a; wr_en = wr; rd_en = !wr; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R5 reset rvalid", {31'h0, rvalid}, 32'h0);
        check("R5 reset rdata", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [60:0] v;
            v = VEC[i];
            access(v[56], v[55:48], v[47:16]);
            if (v[56]) begin
                check($sformatf("R%0d write rvalid low v%0d", v[60:57], i), {31'h0, rvalid}, 32'h0);
            end else begin
                check($sformatf("R%0d read rvalid v%0d", v[60:57], i), {31'h0, rvalid}, 32'h1);
                check($sformatf("R%0d read data v%0d", v[60:57], i), rdata, {16'h0, v[15:0]});
            end
        end

        // R5: idle cycle after a read drops rvalid
        access(1'b0, 8'h10, 32'h0);
        @(negedge clk); @(posedge clk); #1;
        check("R5 rvalid idle", {31'h0, rvalid}, 32'h0);

        // R8 and R1: reset mid-run clears bank and array
        access(1'b1, 8'hFF, 32'h0000_0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(1'b0, 8'hFF, 32'h0);
        check("R1 bank after reset", rdata, 32'h0);
        access(1'b0, 8'h10, 32'h0);
        check("R8 array cleared", rdata, 32'h0);
        access(1'b0, 8'h00, 32'h0);
        check("R8 array cleared addr0", rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule